// File: doc/BRIEF.md
# Capability-Tagged Word Memory

A synchronous, word-addressed storage block. Each data word has one out-of-band tag bit kept in a separate store. A tag of 0 means the word holds plain data. A tag of 1 means the word holds a protected capability. Only a privileged write can set a tag. An ordinary user write always clears the tag of the word it touches, and this holds for a write that changes a single byte. A capability that trusted logic reads back with its tag still set has therefore not been modified by ordinary code since the privileged path wrote it.

There are three access paths:
- A user write port with per-byte enables. It has no tag input.
- A privileged write port that stores a full data word and a tag value in the same cycle.
- One read port with a mode select. A user-mode read never sees the tag. A privileged read reports the tag and raises a capability-valid flag when the tag is 1. A capability-checked read raises a one-cycle fault pulse when the tag is 0.

After reset every tag is 0. The data contents stay undefined until they are written.

Top module: `tagged_word_mem`

## Requirements
- R1: After reset every tag is 0. A privileged read of any address returns rd_tag = 0, and rd_valid, cap_ok and cap_fault are low until the first read.
- R2: A read issued with rd_en in cycle N presents rd_valid = 1, with rd_data and rd_tag, in cycle N+1. With no read in cycle N, rd_valid is 0 in cycle N+1.
- R3: A privileged write stores pwr_data and pwr_tag together. A later privileged read of that address returns both values.
- R4: A user write whose byte-enable mask is nonzero sets the word's tag to 0, whatever data it carries and however few lanes it enables.
- R5: A user write changes only the byte lanes whose uwr_be bit is 1. Bit i covers data bits 8i+7 down to 8i. The other lanes keep their old value.
- R6: A user write with uwr_be = 0 changes neither the data nor the tag of the addressed word.
- R7: When a read and a write target the same address in the same cycle, the read returns the data and tag held before that write.
- R8: A read with rd_mode 2'b00 (user) or 2'b11 (reserved, treated as user) always returns rd_tag = 0 and never raises cap_ok or cap_fault.
- R9: A read with rd_mode 2'b01 (privileged) returns the stored tag on rd_tag. It raises cap_ok for that one cycle exactly when the tag is 1.
- R10: A read with rd_mode 2'b10 (capability-checked) returns the stored tag on rd_tag. It raises cap_fault for that one cycle exactly when the tag is 0.
- R11: When a user write and a privileged write target the same word in the same cycle, the privileged write decides both the data and the tag.
- R12: cap_ok and cap_fault are never high together, and neither is high while rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears tags and read flags |
| uwr_en | input | 1 | User write request |
| uwr_addr | input | ADDR_W | User write word address |
| uwr_data | input | DATA_W | User write data |
| uwr_be | input | DATA_W/BYTE_W | User write byte-lane enables |
| pwr_en | input | 1 | Privileged write request |
| pwr_addr | input | ADDR_W | Privileged write word address |
| pwr_data | input | DATA_W | Privileged write data (full word) |
| pwr_tag | input | 1 | Tag value stored by the privileged write |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_mode | input | 2 | 00 user, 01 privileged, 10 capability-checked, 11 treated as user |
| rd_valid | output | 1 | High one cycle after a read request |
| rd_data | output | DATA_W | Read data, valid while rd_valid is high |
| rd_tag | output | 1 | Read tag; forced to 0 for user-mode reads |
| cap_ok | output | 1 | Privileged read found tag 1 |
| cap_fault | output | 1 | Capability-checked read found tag 0 |

## Verification
Every write takes effect at the clock edge that samples it. Every read result, meaning rd_valid, rd_data, rd_tag, cap_ok and cap_fault, appears exactly one cycle after the edge that sampled rd_en, and it lasts for that single cycle only. The bench drives each request on a falling edge and lets one rising edge capture it. It then samples all read outputs on the next falling edge, which is the middle of the result cycle. The same-cycle collision cases, read against write and user write against privileged write, are driven in a single cycle. Their outcome is read back in the cycle that follows.

// File: rtl/twm_pkg.sv
package twm_pkg;

   // Read mode encoding. The reserved code behaves as a user read.
   typedef enum logic [1:0] {
      RD_USER  = 2'b00,
      RD_PRIV  = 2'b01,
      RD_CHECK = 2'b10,
      RD_RSVD  = 2'b11
   } rd_mode_e;

endpackage

// File: rtl/twm_data_bank.sv
// Data storage, split into independent byte lanes. Each lane has two write
// ports and one registered read port that returns the contents held before
// any write in the same cycle.
module twm_data_bank #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 6,
   localparam int NBYTES = DATA_W / BYTE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              uwr_en,
   input  logic [ADDR_W-1:0] uwr_addr,
   input  logic [DATA_W-1:0] uwr_data,
   input  logic [NBYTES-1:0] uwr_be,
   input  logic              pwr_en,
   input  logic [ADDR_W-1:0] pwr_addr,
   input  logic [DATA_W-1:0] pwr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];
      logic [BYTE_W-1:0] lane_q;

      // Data is deliberately left without reset.
      always_ff @(posedge clk) begin
         if (rd_en)
            lane_q <= lane_mem[rd_addr];
         if (uwr_en && uwr_be[g])
            lane_mem[uwr_addr] <= uwr_data[g*BYTE_W +: BYTE_W];
         // The privileged port is assigned last, so it wins a same-word collision.
         if (pwr_en)
            lane_mem[pwr_addr] <= pwr_data[g*BYTE_W +: BYTE_W];
      end

      assign rd_data[g*BYTE_W +: BYTE_W] = lane_q;
   end

endmodule

// File: rtl/twm_tag_store.sv
// One tag bit per word, held apart from the data. Reset clears every tag.
module twm_tag_store #(
   parameter int ADDR_W = 6,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uwr_hit,
   input  logic [ADDR_W-1:0] uwr_addr,
   input  logic              pwr_en,
   input  logic [ADDR_W-1:0] pwr_addr,
   input  logic              pwr_tag,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_tag
);

   logic [DEPTH-1:0] tag_bits;
   logic             tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_bits <= '0;
         tag_q    <= 1'b0;
      end else begin
         if (rd_en)
            tag_q <= tag_bits[rd_addr];
         // An ordinary store of any width revokes the capability.
         if (uwr_hit)
            tag_bits[uwr_addr] <= 1'b0;
         if (pwr_en)
            tag_bits[pwr_addr] <= pwr_tag;
      end
   end

   assign rd_tag = tag_q;

endmodule

// File: rtl/twm_read_stage.sv
// Turns the raw tag into the flags that the read mode allows.
module twm_read_stage
   import twm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  logic [1:0] rd_mode,
   input  logic       raw_tag,
   output logic       rd_valid,
   output logic       rd_tag,
   output logic       cap_ok,
   output logic       cap_fault
);

   logic     valid_q;
   rd_mode_e mode_q;
   logic     tag_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         mode_q  <= RD_USER;
      end else begin
         valid_q <= rd_en;
         if (rd_en)
            mode_q <= rd_mode_e'(rd_mode);
      end
   end

   // Only the privileged and checked modes may observe the tag.
   assign tag_seen  = valid_q && (mode_q == RD_PRIV || mode_q == RD_CHECK);
   assign rd_valid  = valid_q;
   assign rd_tag    = tag_seen && raw_tag;
   assign cap_ok    = valid_q && (mode_q == RD_PRIV)  &&  raw_tag;
   assign cap_fault = valid_q && (mode_q == RD_CHECK) && !raw_tag;

endmodule

// File: rtl/tagged_word_mem.sv
module tagged_word_mem #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 6,
   localparam int NBYTES = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uwr_en,
   input  logic [ADDR_W-1:0] uwr_addr,
   input  logic [DATA_W-1:0] uwr_data,
   input  logic [NBYTES-1:0] uwr_be,
   input  logic              pwr_en,
   input  logic [ADDR_W-1:0] pwr_addr,
   input  logic [DATA_W-1:0] pwr_data,
   input  logic              pwr_tag,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_mode,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_tag,
   output logic              cap_ok,
   output logic              cap_fault
);

   // Elaboration-time parameter checks
   if (BYTE_W < 1 || DATA_W % BYTE_W != 0) begin : g_bad_lane
      $error("tagged_word_mem: DATA_W must be a multiple of BYTE_W");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("tagged_word_mem: ADDR_W out of supported range");
   end

   logic uwr_hit;
   logic raw_tag;

   assign uwr_hit = uwr_en && (|uwr_be);

   twm_data_bank #(
      .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
   ) u_data (
      .clk      (clk),
      .uwr_en   (uwr_en),
      .uwr_addr (uwr_addr),
      .uwr_data (uwr_data),
      .uwr_be   (uwr_be),
      .pwr_en   (pwr_en),
      .pwr_addr (pwr_addr),
      .pwr_data (pwr_data),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   twm_tag_store #(
      .ADDR_W(ADDR_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .uwr_hit  (uwr_hit),
      .uwr_addr (uwr_addr),
      .pwr_en   (pwr_en),
      .pwr_addr (pwr_addr),
      .pwr_tag  (pwr_tag),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_tag   (raw_tag)
   );

   twm_read_stage u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_mode   (rd_mode),
      .raw_tag   (raw_tag),
      .rd_valid  (rd_valid),
      .rd_tag    (rd_tag),
      .cap_ok    (cap_ok),
      .cap_fault (cap_fault)
   );

endmodule

// File: rtl/twm_checker.sv
module twm_checker
   import twm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 6,
   localparam int NBYTES = DATA_W / BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              uwr_en,
   input logic [ADDR_W-1:0] uwr_addr,
   input logic [DATA_W-1:0] uwr_data,
   input logic [NBYTES-1:0] uwr_be,
   input logic              pwr_en,
   input logic [ADDR_W-1:0] pwr_addr,
   input logic [DATA_W-1:0] pwr_data,
   input logic              pwr_tag,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [1:0]        rd_mode,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_tag,
   input logic              cap_ok,
   input logic              cap_fault
);

   // R2: read result arrives one cycle after the request
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R8: user and reserved modes never expose the tag
   a_r8_tag_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_mode == RD_USER || rd_mode == RD_RSVD)) |=> (!rd_tag && !cap_ok && !cap_fault));

   // R12: flags are exclusive and only accompany a valid read
   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_ok && cap_fault));
   a_r12_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ok || cap_fault) |-> rd_valid);

   // R9: a capability-valid flag implies a visible set tag
   a_r9_ok_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ok |-> rd_tag);

   // R3: a privileged tagged store is seen by a privileged read on the next cycle
   a_r3_priv_store_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_mode == RD_PRIV && $past(pwr_en && pwr_tag) && rd_addr == $past(pwr_addr))
      |=> cap_ok);

   // R4: any enabled user store leaves the tag clear
   a_r4_user_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_mode == RD_PRIV && rd_addr == $past(uwr_addr)
       && $past(uwr_en && (|uwr_be) && !(pwr_en && pwr_addr == uwr_addr)))
      |=> !rd_tag);

endmodule

bind tagged_word_mem twm_checker #(
   .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_twm_chk (.*);

// File: tb/tb_tagged_word_mem.sv
module tb_tagged_word_mem;

   localparam int DATA_W = 32;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 6;
   localparam int NB     = DATA_W / BYTE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              uwr_en = 1'b0;
   logic [ADDR_W-1:0] uwr_addr = '0;
   logic [DATA_W-1:0] uwr_data = '0;
   logic [NB-1:0]     uwr_be = '0;
   logic              pwr_en = 1'b0;
   logic [ADDR_W-1:0] pwr_addr = '0;
   logic [DATA_W-1:0] pwr_data = '0;
   logic              pwr_tag = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [1:0]        rd_mode = 2'b00;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic              rd_tag;
   logic              cap_ok;
   logic              cap_fault;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   always #5 clk = ~clk;

   tagged_word_mem #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) dut (.*);

   localparam logic [1:0] OP_WU = 2'd0, OP_WP = 2'd1, OP_RD = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [5:0]  addr;
      logic [31:0] data;
      logic [3:0]  be;
      logic        tag;
      logic [1:0]  mode;
      logic [31:0] exp_data;
      logic        exp_tag;
      logic        exp_ok;
      logic        exp_fault;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t VECS [NVEC] = '{
      '{OP_WP, 6'd3, 32'hCAFE0001, 4'h0, 1'b1, 2'b00, 32'h0,        1'b0, 1'b0, 1'b0, 8'd3},
      '{OP_RD, 6'd3, 32'h0,        4'h0, 1'b0, 2'b01, 32'hCAFE0001, 1'b1, 1'b1, 1'b0, 8'd9},  // R3 R9
      '{OP_RD, 6'd3, 32'h0,        4'h0, 1'b0, 2'b10, 32'hCAFE0001, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 no fault
      '{OP_RD, 6'd3, 32'h0,        4'h0, 1'b0, 2'b00, 32'hCAFE0001, 1'b0, 1'b0, 1'b0, 8'd8},  // R8
      '{OP_WU, 6'd3, 32'h0000AB00, 4'h2, 1'b0, 2'b00, 32'h0,        1'b0, 1'b0, 1'b0, 8'd5},
      '{OP_RD, 6'd3, 32'h0,        4'h0, 1'b0, 2'b10, 32'hCAFEAB01, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 R5 R10
      '{OP_WP, 6'd9, 32'h12345678, 4'h0, 1'b1, 2'b00, 32'h0,        1'b0, 1'b0, 1'b0, 8'd3},
      '{OP_WU, 6'd9, 32'hFFFFFFFF, 4'h0, 1'b0, 2'b00, 32'h0,        1'b0, 1'b0, 1'b0, 8'd6},
      '{OP_RD, 6'd9, 32'h0,        4'h0, 1'b0, 2'b01, 32'h12345678, 1'b1, 1'b1, 1'b0, 8'd6},  // R6
      '{OP_WP, 6'd9, 32'h11112222, 4'h0, 1'b0, 2'b00, 32'h0,        1'b0, 1'b0, 1'b0, 8'd3},
      '{OP_RD, 6'd9, 32'h0,        4'h0, 1'b0, 2'b10, 32'h11112222, 1'b0, 1'b0, 1'b1, 8'd3},  // R3 tag 0
      '{OP_WU, 6'd5, 32'hA5A5A5A5, 4'hF, 1'b0, 2'b00, 32'h0,        1'b0, 1'b0, 1'b0, 8'd4},
      '{OP_RD, 6'd5, 32'h0,        4'h0, 1'b0, 2'b01, 32'hA5A5A5A5, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 full word
      '{OP_RD, 6'd5, 32'h0,        4'h0, 1'b0, 2'b11, 32'hA5A5A5A5, 1'b0, 1'b0, 1'b0, 8'd8}   // R8 reserved
   };

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr_user(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      uwr_en = 1'b1; uwr_addr = a; uwr_data = d; uwr_be = be;
      @(negedge clk);
      uwr_en = 1'b0;
   endtask

   task automatic wr_priv(input logic [5:0] a, input logic [31:0] d, input logic t);
      @(negedge clk);
      pwr_en = 1'b1; pwr_addr = a; pwr_data = d; pwr_tag = t;
      @(negedge clk);
      pwr_en = 1'b0;
   endtask

   // Issues a read and returns at the falling edge of the result cycle.
   task automatic rd(input logic [5:0] a, input logic [1:0] m);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; rd_mode = m;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_read(input int req, input logic [31:0] ed, input logic et,
                           input logic eo, input logic ef);
      chk(2,   "rd_valid", {31'b0, rd_valid}, 32'd1);
      chk(req, "rd_data",  rd_data, ed);
      chk(req, "rd_tag",   {31'b0, rd_tag}, {31'b0, et});
      chk(req, "cap_ok",   {31'b0, cap_ok}, {31'b0, eo});
      chk(req, "cap_fault",{31'b0, cap_fault}, {31'b0, ef});
      chk(12,  "flags exclusive", {31'b0, cap_ok && cap_fault}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk(1, "rd_valid in reset", {31'b0, rd_valid}, 32'd0);
      chk(12, "flags in reset", {30'b0, cap_ok, cap_fault}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, "rd_valid after reset", {31'b0, rd_valid}, 32'd0);

      // R1: tags clear at reset, sampled at several addresses
      for (int i = 0; i < 4; i++) begin
         rd(6'(i * 21), 2'b01);
         chk(1, "tag after reset", {31'b0, rd_tag}, 32'd0);
         chk(1, "cap_ok after reset", {31'b0, cap_ok}, 32'd0);
      end
      // R2: result lasts one cycle only
      @(negedge clk);
      chk(2, "rd_valid drops", {31'b0, rd_valid}, 32'd0);

      // Vector table
      for (int v = 0; v < NVEC; v++) begin
         case (VECS[v].op)
            OP_WU: wr_user(VECS[v].addr, VECS[v].data, VECS[v].be);
            OP_WP: wr_priv(VECS[v].addr, VECS[v].data, VECS[v].tag);
            default: begin
               rd(VECS[v].addr, VECS[v].mode);
               chk_read(int'(VECS[v].req), VECS[v].exp_data, VECS[v].exp_tag,
                        VECS[v].exp_ok, VECS[v].exp_fault);
            end
         endcase
      end

      // R5: single-lane user store at the top byte keeps the other lanes
      wr_priv(6'd40, 32'h01020304, 1'b1);
      wr_user(6'd40, 32'hEE000000, 4'h8);
      rd(6'd40, 2'b01);
      chk_read(5, 32'hEE020304, 1'b0, 1'b0, 1'b0);

      // R7: read and privileged write to the same word in one cycle
      wr_priv(6'd20, 32'hAAAA0000, 1'b1);
      @(negedge clk);
      pwr_en = 1'b1; pwr_addr = 6'd20; pwr_data = 32'hBBBB1111; pwr_tag = 1'b0;
      rd_en = 1'b1; rd_addr = 6'd20; rd_mode = 2'b01;
      @(negedge clk);
      pwr_en = 1'b0; rd_en = 1'b0;
      chk_read(7, 32'hAAAA0000, 1'b1, 1'b1, 1'b0);
      rd(6'd20, 2'b10);
      chk_read(7, 32'hBBBB1111, 1'b0, 1'b0, 1'b1);

      // R7: read and user write in one cycle keeps the old tag visible
      wr_priv(6'd21, 32'h0000C0DE, 1'b1);
      @(negedge clk);
      uwr_en = 1'b1; uwr_addr = 6'd21; uwr_data = 32'hFFFFFFFF; uwr_be = 4'h1;
      rd_en = 1'b1; rd_addr = 6'd21; rd_mode = 2'b10;
      @(negedge clk);
      uwr_en = 1'b0; rd_en = 1'b0;
      chk_read(7, 32'h0000C0DE, 1'b1, 1'b0, 1'b0);

      // R11: colliding user and privileged stores, privileged one decides
      @(negedge clk);
      uwr_en = 1'b1; uwr_addr = 6'd30; uwr_data = 32'h00000001; uwr_be = 4'hF;
      pwr_en = 1'b1; pwr_addr = 6'd30; pwr_data = 32'h00000002; pwr_tag = 1'b1;
      @(negedge clk);
      uwr_en = 1'b0; pwr_en = 1'b0;
      rd(6'd30, 2'b01);
      chk_read(11, 32'h00000002, 1'b1, 1'b1, 1'b0);

      // R8: user-mode read of a live capability still hides the tag
      rd(6'd30, 2'b00);
      chk_read(8, 32'h00000002, 1'b0, 1'b0, 1'b0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule